// File: doc/BRIEF.md
# Parallel Port FIFO Interrupt Generator

This block merges four interrupt conditions of an extended-capability parallel port into one interrupt line. One condition is a level: an enabled, low acknowledge input from the peripheral. The other three produce pulses of a guaranteed minimum width:
- an error or fault edge seen in extended-capability mode;
- a FIFO service threshold in the FIFO-based modes when DMA is off;
- a DMA terminal count while the DMA acknowledge is active.

The FIFO threshold source and the terminal-count source each shut themselves off. When either one fires, the block raises a one-cycle request for the register file to set the service bit. While that bit is set, both sources are held off, and DMA requests stop as well. The block takes the mode, transfer direction, FIFO fill count, control bits and status lines as inputs. It holds no register file and no IRQ routing.

Top module: `ppfifo_irq_gen`

## Requirements
- R1: `irq_o` is 1 in the cycle after any clock edge at which `ack_irq_en_i` is 1 and `ack_n_i` is 0, and follows that level with one register of delay.
- R2: In mode 3'b011 only, a falling `fault_n_i` (1 at one clock edge, 0 at the next) while `err_mask_i` is 0 starts an interrupt pulse.
- R3: In mode 3'b011 only, a falling `err_mask_i` while `fault_n_i` is 0 at both edges starts an interrupt pulse. Neither edge source fires in the first cycle after reset.
- R4: In direction 0 (`dir_i`=0), the threshold source fires when the empty count, DEPTH minus `fill_cnt_i`, is at least 8.
- R5: In direction 1, the threshold source fires when `fill_cnt_i` is at least 8.
- R6: The threshold source is active only in FIFO modes 3'b010, 3'b011 and 3'b110, and only with `dma_en_i`=0 and `svc_i`=0.
- R7: The terminal-count source fires in the FIFO modes when `dma_en_i`=1, `svc_i`=0, `tc_i`=1 and `dma_ack_n_i`=0.
- R8: A firing of the threshold or terminal-count source raises `svc_set_o` for exactly one cycle, in the cycle after the trigger edge. Neither source fires while `svc_set_o` is high.
- R9: A pulse holds its share of `irq_o` for PULSE_CYC cycles. A new trigger during a pulse restarts the full count.
- R10: `irq_o` is the OR of the level source of R1 and the pulse of R9.
- R11: During and straight after reset, `irq_o` and `svc_set_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 3 | Port operating mode |
| dir_i | input | 1 | Transfer direction, 0 = host to peripheral |
| fill_cnt_i | input | CNT_W | Bytes currently held in the FIFO (0..DEPTH) |
| ack_irq_en_i | input | 1 | Acknowledge interrupt enable |
| ack_n_i | input | 1 | Peripheral acknowledge, active low |
| err_mask_i | input | 1 | Error interrupt mask bit |
| fault_n_i | input | 1 | Peripheral fault/error, active low |
| dma_en_i | input | 1 | DMA enable bit |
| svc_i | input | 1 | Service interrupt bit (1 = sources 3/4 off) |
| tc_i | input | 1 | DMA terminal count |
| dma_ack_n_i | input | 1 | DMA acknowledge, active low |
| irq_o | output | 1 | Combined interrupt |
| svc_set_o | output | 1 | One-cycle request to set the service bit |

## Verification
The threshold source is swept over every mode, both directions, every fill count from 0 to 16 and both DMA settings. This separates the direction-aware compare at the 7/8/9 boundaries and the decode of the FIFO modes from the non-FIFO modes. Error edges and mask edges are driven in every mode, each with the other input in both states. This shows which of the two edge forms fires, and that neither fires outside extended-capability mode. Terminal count is tried against every combination of acknowledge, DMA enable and service bit. Edges spaced closer than the pulse width then show that a new trigger restarts the pulse instead of being lost or queued.

// File: rtl/ppirq_pkg.sv
package ppirq_pkg;

    typedef enum logic [2:0] {
        PM_COMPAT  = 3'b000,
        PM_BIDIR   = 3'b001,
        PM_FIFOCMP = 3'b010,
        PM_EXTCAP  = 3'b011,
        PM_ENHANCE = 3'b100,
        PM_RSVD    = 3'b101,
        PM_TEST    = 3'b110,
        PM_CONFIG  = 3'b111
    } port_mode_e;

    function automatic logic is_fifo_mode(input logic [2:0] m);
        return (m == PM_FIFOCMP) || (m == PM_EXTCAP) || (m == PM_TEST);
    endfunction

    function automatic logic is_extcap_mode(input logic [2:0] m);
        return m == PM_EXTCAP;
    endfunction

endpackage

// File: rtl/ppirq_edge_src.sv
module ppirq_edge_src (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic fault_n_i,
    input  logic mask_i,
    output logic trig_o
);

    typedef struct packed {
        logic prev_fault_n;
        logic prev_mask;
        logic primed;
    } edge_st_t;

    edge_st_t st_d, st_q;
    logic fault_fall, mask_fall;

    always_comb begin
        st_d              = st_q;
        st_d.prev_fault_n = fault_n_i;
        st_d.prev_mask    = mask_i;
        st_d.primed       = 1'b1;
        fault_fall = st_q.primed && st_q.prev_fault_n && !fault_n_i && !mask_i;
        mask_fall  = st_q.primed && st_q.prev_mask && !mask_i && !fault_n_i;
        trig_o     = enable_i && (fault_fall || mask_fall);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/ppirq_fifo_src.sv
module ppirq_fifo_src #(
    parameter int DEPTH  = 16,
    parameter int THRESH = 8,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic             fifo_en_i,
    input  logic             dir_i,
    input  logic [CNT_W-1:0] fill_i,
    input  logic             dma_en_i,
    input  logic             svc_i,
    input  logic             tc_i,
    input  logic             dma_ack_n_i,
    input  logic             hold_i,
    output logic             thr_trig_o,
    output logic             tc_trig_o
);

    localparam logic [CNT_W-1:0] DEPTH_C  = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] THRESH_C = CNT_W'(THRESH);

    logic [CNT_W-1:0] empty_cnt;
    logic             level_met;
    logic             armed;

    always_comb begin
        empty_cnt  = DEPTH_C - fill_i;
        level_met  = dir_i ? (fill_i >= THRESH_C) : (empty_cnt >= THRESH_C);
        armed      = fifo_en_i && !svc_i && !hold_i;
        thr_trig_o = armed && !dma_en_i && level_met;
        tc_trig_o  = armed && dma_en_i && tc_i && !dma_ack_n_i;
    end

endmodule

// File: rtl/ppirq_stretch.sv
module ppirq_stretch #(
    parameter int PULSE_CYC = 10,
    parameter int PW_W      = $clog2(PULSE_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    output logic pulse_o
);

    localparam logic [PW_W-1:0] LOAD = PW_W'(PULSE_CYC);

    logic [PW_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (trig_i)            cnt_d = LOAD;
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
        else                   cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign pulse_o = (cnt_q != '0);

endmodule

// File: rtl/ppfifo_irq_gen.sv
module ppfifo_irq_gen #(
    parameter int DEPTH     = 16,
    parameter int THRESH    = 8,
    parameter int PULSE_CYC = 10,
    parameter int CNT_W     = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       mode_i,
    input  logic             dir_i,
    input  logic [CNT_W-1:0] fill_cnt_i,
    input  logic             ack_irq_en_i,
    input  logic             ack_n_i,
    input  logic             err_mask_i,
    input  logic             fault_n_i,
    input  logic             dma_en_i,
    input  logic             svc_i,
    input  logic             tc_i,
    input  logic             dma_ack_n_i,
    output logic             irq_o,
    output logic             svc_set_o
);
    import ppirq_pkg::*;

    typedef struct packed {
        logic level;
        logic svc_set;
    } top_st_t;

    top_st_t st_d, st_q;
    logic edge_trig, thr_trig, tc_trig, pulse_trig, pulse;

    ppirq_edge_src u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable_i  (is_extcap_mode(mode_i)),
        .fault_n_i (fault_n_i),
        .mask_i    (err_mask_i),
        .trig_o    (edge_trig)
    );

    ppirq_fifo_src #(.DEPTH(DEPTH), .THRESH(THRESH), .CNT_W(CNT_W)) u_fifo (
        .fifo_en_i   (is_fifo_mode(mode_i)),
        .dir_i       (dir_i),
        .fill_i      (fill_cnt_i),
        .dma_en_i    (dma_en_i),
        .svc_i       (svc_i),
        .tc_i        (tc_i),
        .dma_ack_n_i (dma_ack_n_i),
        .hold_i      (st_q.svc_set),
        .thr_trig_o  (thr_trig),
        .tc_trig_o   (tc_trig)
    );

    assign pulse_trig = edge_trig || thr_trig || tc_trig;

    ppirq_stretch #(.PULSE_CYC(PULSE_CYC)) u_stretch (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig_i  (pulse_trig),
        .pulse_o (pulse)
    );

    always_comb begin
        st_d         = st_q;
        st_d.level   = ack_irq_en_i && !ack_n_i;
        st_d.svc_set = thr_trig || tc_trig;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o     = st_q.level || pulse;
    assign svc_set_o = st_q.svc_set;

endmodule

// File: rtl/ppfifo_irq_gen_chk.sv
module ppfifo_irq_gen_chk #(
    parameter int DEPTH  = 16,
    parameter int THRESH = 8,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       mode_i,
    input logic             dir_i,
    input logic [CNT_W-1:0] fill_cnt_i,
    input logic             ack_irq_en_i,
    input logic             ack_n_i,
    input logic             dma_en_i,
    input logic             svc_i,
    input logic             tc_i,
    input logic             dma_ack_n_i,
    input logic             irq_o,
    input logic             svc_set_o
);
    import ppirq_pkg::*;

    logic fifo_m;
    assign fifo_m = is_fifo_mode(mode_i);

    always_comb begin
        if (!rst_n) begin
            a_r11_reset_quiet: assert (!svc_set_o);
        end
    end

    a_r1_level_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_irq_en_i && !ack_n_i) |=> irq_o);

    a_r8_single_set: assert property (@(posedge clk) disable iff (!rst_n)
        svc_set_o |=> !svc_set_o);

    a_r4_empty_thresh: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_m && !dir_i && !dma_en_i && !svc_i && !svc_set_o &&
         (CNT_W'(DEPTH) - fill_cnt_i) >= CNT_W'(THRESH)) |=> (svc_set_o && irq_o));

    a_r7_tc_fire: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_m && dma_en_i && !svc_i && tc_i && !dma_ack_n_i && !svc_set_o)
        |=> (svc_set_o && irq_o));

    a_r6_no_set_outside_fifo: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_m || svc_i) |=> !svc_set_o);

    a_r9_set_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        svc_set_o |-> irq_o);

endmodule

bind ppfifo_irq_gen ppfifo_irq_gen_chk #(.DEPTH(DEPTH), .THRESH(THRESH), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_i       (mode_i),
    .dir_i        (dir_i),
    .fill_cnt_i   (fill_cnt_i),
    .ack_irq_en_i (ack_irq_en_i),
    .ack_n_i      (ack_n_i),
    .dma_en_i     (dma_en_i),
    .svc_i        (svc_i),
    .tc_i         (tc_i),
    .dma_ack_n_i  (dma_ack_n_i),
    .irq_o        (irq_o),
    .svc_set_o    (svc_set_o)
);

// File: tb/tb_ppfifo_irq_gen.sv
`timescale 1ns/1ps
module tb_ppfifo_irq_gen;

    localparam int DEPTH = 16;
    localparam int PW    = 10;
    localparam int CW    = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    mode = 3'd0;
    logic          dir = 1'b0;
    logic [CW-1:0] fill = '0;
    logic          aie = 1'b0, ack_n = 1'b1, mask = 1'b1, fault_n = 1'b1;
    logic          dma = 1'b0, svc = 1'b1, tc = 1'b0, dack_n = 1'b1;
    logic          irq, sset;

    int n_run = 0, n_fail = 0;
    string tag = "R11";

    int m_cnt = 0;
    bit m_lvl = 0, m_set = 0, m_pf = 0, m_pm = 0, m_primed = 0;

    always #2.5 clk = ~clk;

    ppfifo_irq_gen #(.DEPTH(DEPTH), .THRESH(8), .PULSE_CYC(PW)) dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .dir_i(dir), .fill_cnt_i(fill),
        .ack_irq_en_i(aie), .ack_n_i(ack_n), .err_mask_i(mask), .fault_n_i(fault_n),
        .dma_en_i(dma), .svc_i(svc), .tc_i(tc), .dma_ack_n_i(dack_n),
        .irq_o(irq), .svc_set_o(sset)
    );

    task automatic chk(input string t, input logic act, input logic exp, input string what);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", t, what, act, exp, $time);
        end
    endtask

    // advance one clock: model reacts to inputs at this edge, compare at next negedge
    task automatic step();
        bit fifo_m, ecp, t2, t3, t4, thr, prev_set;
        int empty;
        fifo_m = (mode == 3'b010) || (mode == 3'b011) || (mode == 3'b110);
        ecp    = (mode == 3'b011);
        empty  = DEPTH - int'(fill);
        thr    = dir ? (int'(fill) >= 8) : (empty >= 8);
        t2 = ecp && m_primed && ((m_pf && !fault_n && !mask) || (m_pm && !mask && !fault_n));
        t3 = fifo_m && !dma && !svc && !m_set && thr;
        t4 = fifo_m && dma && !svc && !m_set && tc && !dack_n;
        prev_set = m_set;
        @(posedge clk);
        m_cnt    = (t2 || t3 || t4) ? PW : ((m_cnt > 0) ? m_cnt - 1 : 0);
        m_lvl    = aie && !ack_n;
        m_set    = t3 || t4;
        m_pf     = fault_n;
        m_pm     = mask;
        m_primed = 1;
        @(negedge clk);
        if (prev_set) svc = 1'b1;
        chk(tag, irq, m_lvl || (m_cnt > 0), "irq_o");
        chk(tag, sset, m_set, "svc_set_o");
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R11: reset state
        repeat (3) @(negedge clk);
        chk("R11", irq, 1'b0, "irq_o in reset");
        chk("R11", sset, 1'b0, "svc_set_o in reset");
        rst_n = 1'b1;
        tag = "R11";
        idle(2);

        // R1/R10: level source, all four combinations
        tag = "R1";
        for (int k = 0; k < 4; k++) begin
            aie = k[0]; ack_n = k[1];
            idle(3);
        end
        aie = 0; ack_n = 1;
        idle(2);

        // R4/R5/R6: threshold sweep over mode, direction, fill, DMA
        for (int m = 0; m < 8; m++)
            for (int d = 0; d < 2; d++)
                for (int f = 0; f <= DEPTH; f++)
                    for (int e = 0; e < 2; e++) begin
                        tag = (e == 1 || !((m == 2) || (m == 3) || (m == 6))) ? "R6" :
                              (d == 0 ? "R4" : "R5");
                        mode = 3'(m); dir = d[0]; fill = CW'(f); dma = e[0];
                        svc = 1'b0;
                        idle(PW + 3);
                        svc = 1'b1;
                        idle(1);
                    end
        dma = 0; fill = '0; svc = 1;

        // R2/R3: edge sources in every mode
        for (int m = 0; m < 8; m++) begin
            mode = 3'(m);
            tag = "R2";
            mask = 0; fault_n = 1; idle(2);
            fault_n = 0; idle(PW + 2);
            mask = 1; fault_n = 1; idle(1);
            fault_n = 0; idle(PW + 2);   // masked: no pulse
            tag = "R3";
            fault_n = 0; mask = 1; idle(2);
            mask = 0; idle(PW + 2);
            fault_n = 1; mask = 1; idle(1);
            mask = 0; idle(PW + 2);      // fault high: no pulse
            mask = 1; fault_n = 1; idle(1);
        end

        // R7/R8: terminal count against ack, dma enable, service bit
        fill = CW'(8);
        for (int m = 0; m < 8; m++)
            for (int k = 0; k < 8; k++) begin
                mode = 3'(m); tag = "R7";
                dma = k[0]; dack_n = k[1]; svc = k[2];
                dir = 1'b0; fill = CW'(12);   // keeps threshold source quiet
                tc = 1'b1; idle(1);
                tag = "R8";
                idle(2);
                tc = 1'b0; idle(PW);
            end
        dma = 0; dack_n = 1; svc = 1; fill = '0;

        // R9/R10: restart of the pulse by close retriggers, plus level overlap
        mode = 3'b011; tag = "R9";
        for (int r = 0; r < 4; r++) begin
            mask = 0; fault_n = 1; idle(1);
            fault_n = 0; idle(4);
        end
        idle(PW + 2);
        tag = "R10";
        aie = 1; ack_n = 0; idle(1);
        mask = 0; fault_n = 1; idle(1);
        fault_n = 0; idle(3);
        ack_n = 1; idle(PW + 2);
        aie = 0; mask = 1; fault_n = 1; mode = 3'd0; idle(2);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule